// File: doc/BRIEF.md
# Cable Presence Detect Controller

This block is the control state machine for a two-channel serial link repeater. Its job is to decide whether an external drive hangs off the peripheral-facing connector, and to report that decision on an active-low presence output. The host watches this output. The host can power down its link while no drive is present, and power the link up again once one appears.

The analog front end supplies flags to the block:

- Four level flags: supply-valid, enable, detect-feature select, and a termination-present sense taken on the channel-1 outputs. Each level flag passes through a two-flop synchronizer.
- Two single-cycle synchronous strobes: a valid host out-of-band burst, and a peripheral initialization burst seen on channel 2.

Absence is declared only in one case. A host out-of-band burst must find the channel-1 termination open, and the termination must stay open for a parameterized qualification window. After that the block parks in a listen state with channel 1 disabled, and it waits for the peripheral's initialization burst.

The enable and detect-select inputs are meant to be tied or pulled high at integration. With that default, detection is enabled and the device is active. An encoded state output exposes the machine for test.

Top module: `cable_presence_ctrl`

## Requirements
- R1: While reset is asserted or supply-valid is low, stateOut is 0 (off). In this state presentN is 0, ch1Disable is 0 and standbyReq is 1.
- R2: Once supply is valid with enable and detect-select high, the block reaches stateOut 3 (monitor) with presentN 0, ch1Disable 0 and standbyReq 0.
- R3: With enable low, stateOut is 1 (standby), standbyReq is 1 and presentN is 0. When enable returns high, the block passes through state 0 and re-evaluates detect-select.
- R4: With detect-select low, stateOut is 2 (bypass) and presentN stays 0. termSense and both strobes have no effect in this state.
- R5: In monitor, termSense is ignored without a host burst strobe. An open termination leaves presentN at 0 for as long as no strobe arrives.
- R6: A host burst strobe in monitor while termSense is high keeps stateOut at 3 and presentN at 0.
- R7: A host burst strobe in monitor while termSense is low moves the block to stateOut 4 (qualify), where presentN stays 0 for QUAL_CYCLES cycles. If termSense returns high inside that window, the block goes back to monitor with presentN 0.
- R8: If termSense stays low for the whole window, the block moves to stateOut 5 (listen) with presentN 1 and ch1Disable 1.
- R9: In listen, a peripheral init strobe returns the block to monitor with presentN 0 and ch1Disable 0. Host burst strobes are ignored in listen.
- R10: A low supply-valid overrides every other input and state. A low enable overrides detect-select. Dropping detect-select in listen goes to bypass.
- R11: A level change on supplyOk, enableIn, detectSel or termSense shows on stateOut at the third rising clock edge after it is applied, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; forces the off state |
| supplyOk | input | 1 | Supply valid level (asynchronous) |
| enableIn | input | 1 | Device enable level (asynchronous) |
| detectSel | input | 1 | Cable-detect feature select level (asynchronous) |
| termSense | input | 1 | Channel-1 output termination present (asynchronous) |
| hostOobStb | input | 1 | One-cycle strobe: valid host out-of-band burst |
| devInitStb | input | 1 | One-cycle strobe: peripheral init burst on channel 2 |
| presentN | output | 1 | 0 = drive attached, 1 = no drive |
| ch1Disable | output | 1 | Channel-1 driver disable (listen state) |
| standbyReq | output | 1 | Standby request to the analog front end |
| stateOut | output | 3 | Encoded state: 0 off, 1 standby, 2 bypass, 3 monitor, 4 qualify, 5 listen |

## Verification
The bench covers the following corner cases:

- An open termination with no host burst. A design that sampled the sense continuously would raise presentN without any strobe, which is the drive-pulled-during-link-sleep case.
- A termination that closes again partway through the qualification window. A design that latched on the strobe alone would falsely declare absence.
- An exact count of the window length, which catches off-by-one counters.
- Host bursts delivered while listening. A design that re-evaluated on them would leave listen without a peripheral init burst.
- The priority of supply over enable over detect-select.
- The synchronizer latency.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_STANDBY = 3'd1,
    ST_BYPASS  = 3'd2,
    ST_MONITOR = 3'd3,
    ST_QUALIFY = 3'd4,
    ST_LISTEN  = 3'd5
  } cpdState_e;

  // control -> datapath
  typedef struct packed {
    logic qualClr;
    logic qualRun;
  } cpdStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic supplyOk;
    logic enableOk;
    logic detectOn;
    logic termOk;
    logic qualDone;
  } cpdStatus_t;

  localparam int LEVEL_COUNT = 4;

endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/cpd_datapath.sv
module cpd_datapath
  import cpd_pkg::*;
#(
  parameter int QUAL_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       enableIn,
  input  logic       detectSel,
  input  logic       termSense,
  input  cpdStrobe_t strobe,
  output cpdStatus_t status
);

  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [LEVEL_COUNT-1:0] levelRaw;
  logic [LEVEL_COUNT-1:0] levelSync;
  logic [CNT_W-1:0]       qualCnt;

  assign levelRaw = {supplyOk, enableIn, detectSel, termSense};

  cpd_sync #(
    .WIDTH  (LEVEL_COUNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (levelRaw),
    .syncOut (levelSync)
  );

  // qualification counter: counts consecutive open-termination cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              qualCnt <= '0;
    else if (strobe.qualClr) qualCnt <= '0;
    else if (strobe.qualRun) qualCnt <= qualCnt + 1'b1;
  end

  assign status.supplyOk = levelSync[3];
  assign status.enableOk = levelSync[2];
  assign status.detectOn = levelSync[1];
  assign status.termOk   = levelSync[0];
  assign status.qualDone = (qualCnt == LAST);

endmodule

// File: rtl/cpd_control.sv
module cpd_control
  import cpd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cpdStatus_t status,
  input  logic       hostOobStb,
  input  logic       devInitStb,
  output cpdStrobe_t strobe,
  output logic [2:0] stateOut,
  output logic       presentN,
  output logic       ch1Disable,
  output logic       standbyReq
);

  cpdState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!status.supplyOk) begin
      nextState = ST_OFF;
    end else if (!status.enableOk) begin
      nextState = ST_STANDBY;
    end else begin
      unique case (state)
        ST_OFF:     nextState = status.detectOn ? ST_MONITOR : ST_BYPASS;
        ST_STANDBY: nextState = ST_OFF;
        ST_BYPASS:  if (status.detectOn) nextState = ST_MONITOR;
        ST_MONITOR: begin
          if (!status.detectOn) begin
            nextState = ST_BYPASS;
          end else if (hostOobStb && !status.termOk) begin
            nextState      = ST_QUALIFY;
            strobe.qualClr = 1'b1;
          end
        end
        ST_QUALIFY: begin
          if (!status.detectOn) begin
            nextState = ST_BYPASS;
          end else if (status.termOk) begin
            nextState = ST_MONITOR;
          end else begin
            strobe.qualRun = 1'b1;
            if (status.qualDone) nextState = ST_LISTEN;
          end
        end
        ST_LISTEN: begin
          if (!status.detectOn)  nextState = ST_BYPASS;
          else if (devInitStb)   nextState = ST_MONITOR;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  assign stateOut   = state;
  assign presentN   = (state == ST_LISTEN);
  assign ch1Disable = (state == ST_LISTEN);
  assign standbyReq = (state == ST_OFF) || (state == ST_STANDBY);

endmodule

// File: rtl/cable_presence_ctrl.sv
module cable_presence_ctrl
  import cpd_pkg::*;
#(
  parameter int QUAL_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       enableIn,
  input  logic       detectSel,
  input  logic       termSense,
  input  logic       hostOobStb,
  input  logic       devInitStb,
  output logic       presentN,
  output logic       ch1Disable,
  output logic       standbyReq,
  output logic [2:0] stateOut
);

  cpdStrobe_t strobe;
  cpdStatus_t status;

  cpd_datapath #(
    .QUAL_CYCLES (QUAL_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .enableIn  (enableIn),
    .detectSel (detectSel),
    .termSense (termSense),
    .strobe    (strobe),
    .status    (status)
  );

  cpd_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .status     (status),
    .hostOobStb (hostOobStb),
    .devInitStb (devInitStb),
    .strobe     (strobe),
    .stateOut   (stateOut),
    .presentN   (presentN),
    .ch1Disable (ch1Disable),
    .standbyReq (standbyReq)
  );

endmodule

// File: rtl/cable_presence_chk.sv
module cable_presence_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostOobStb,
  input logic       devInitStb,
  input logic       presentN,
  input logic       ch1Disable,
  input logic       standbyReq,
  input logic [2:0] stateOut
);

  assert_absence_after_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(presentN) |-> $past(stateOut) == 3'd4);

  assert_ch1_off_after_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ch1Disable) |-> $past(stateOut) == 3'd4);

  assert_qualify_needs_host_burst_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd4 && $past(stateOut) == 3'd3) |-> $past(hostOobStb));

  assert_listen_exit_on_init_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateOut) == 3'd5 && stateOut == 3'd3) |-> $past(devInitStb));

  assert_standby_shows_present_R3: assert property (@(posedge clk) disable iff (!rstN)
    standbyReq |-> (!presentN && !ch1Disable));

  assert_supply_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateOut) == 3'd0 && stateOut != 3'd0) |-> stateOut inside {3'd1, 3'd2, 3'd3});

endmodule

bind cable_presence_ctrl cable_presence_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostOobStb (hostOobStb),
  .devInitStb (devInitStb),
  .presentN   (presentN),
  .ch1Disable (ch1Disable),
  .standbyReq (standbyReq),
  .stateOut   (stateOut)
);

// File: tb/cable_presence_ctrl_bench.sv
`timescale 1ns/1ps
module cable_presence_ctrl_bench;

  localparam int QUAL = 8;
  localparam int NVEC = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       supplyOk = 1'b0, enableIn = 1'b1, detectSel = 1'b1, termSense = 1'b1;
  logic       hostOobStb = 1'b0, devInitStb = 1'b0;
  logic       presentN, ch1Disable, standbyReq;
  logic [2:0] stateOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cable_presence_ctrl #(.QUAL_CYCLES(QUAL)) u_cable_presence_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enableIn(enableIn),
    .detectSel(detectSel), .termSense(termSense), .hostOobStb(hostOobStb),
    .devInitStb(devInitStb), .presentN(presentN), .ch1Disable(ch1Disable),
    .standbyReq(standbyReq), .stateOut(stateOut)
  );

  // {supply, enable, detect, term, expState[2:0], presentN, ch1Disable, standbyReq, req[3:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {4'b0111, 3'd0, 3'b001, 4'd1},   // R1 supply low
    {4'b1111, 3'd3, 3'b000, 4'd2},   // R2 monitor
    {4'b1011, 3'd1, 3'b001, 4'd3},   // R3 standby
    {4'b1111, 3'd3, 3'b000, 4'd3},   // R3 re-evaluate
    {4'b1101, 3'd2, 3'b000, 4'd4},   // R4 bypass
    {4'b1100, 3'd2, 3'b000, 4'd4},   // R4 term ignored
    {4'b1000, 3'd1, 3'b001, 4'd10},  // R10 enable beats detect
    {4'b0000, 3'd0, 3'b001, 4'd10},  // R10 supply beats all
    {4'b1110, 3'd3, 3'b000, 4'd5},   // R5 open term, no strobe
    {4'b1111, 3'd3, 3'b000, 4'd6}    // R6 base
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] obs();
    return {stateOut, presentN, ch1Disable, standbyReq};
  endfunction

  task automatic pulseHost();
    hostOobStb = 1'b1; step(1); hostOobStb = 1'b0;
  endtask

  task automatic pulseDev();
    devInitStb = 1'b1; step(1); devInitStb = 1'b0;
  endtask

  task automatic goListen();
    termSense = 1'b0; step(5);
    pulseHost();
    step(QUAL);
  endtask

  initial begin
    step(2);
    check(1, obs(), {3'd0, 3'b001});  // R1 in reset
    rstN = 1'b1;
    step(1);

    for (int i = 0; i < NVEC; i++) begin
      {supplyOk, enableIn, detectSel, termSense} = VEC[i][13:10];
      step(6);
      check(int'(VEC[i][3:0]), obs(), VEC[i][9:4]);
    end

    // R11 synchronizer latency: detect drop
    detectSel = 1'b0;
    step(2);
    check(11, obs(), {3'd3, 3'b000});
    step(1);
    check(11, obs(), {3'd2, 3'b000});
    detectSel = 1'b1; step(6);

    // R6 strobe with termination present
    pulseHost();
    check(6, obs(), {3'd3, 3'b000});
    step(3);
    check(6, obs(), {3'd3, 3'b000});

    // R7 window then abort
    termSense = 1'b0; step(5);
    pulseHost();
    check(7, obs(), {3'd4, 3'b000});
    step(1);
    termSense = 1'b1;
    step(5);
    check(7, obs(), {3'd3, 3'b000});

    // R7/R8 exact window length
    termSense = 1'b0; step(5);
    pulseHost();
    step(QUAL - 1);
    check(7, obs(), {3'd4, 3'b000});
    step(1);
    check(8, obs(), {3'd5, 3'b110});

    // R9 host burst ignored, init strobe exits
    pulseHost();
    step(3);
    check(9, obs(), {3'd5, 3'b110});
    pulseDev();
    check(9, obs(), {3'd3, 3'b000});
    step(4);
    check(9, obs(), {3'd3, 3'b000});

    // R4 init strobe ignored in bypass
    detectSel = 1'b0; step(6);
    pulseDev(); pulseHost();
    check(4, obs(), {3'd2, 3'b000});
    detectSel = 1'b1; step(6);

    // R10 detect drop from listen
    goListen();
    check(8, obs(), {3'd5, 3'b110});
    detectSel = 1'b0; step(3);
    check(10, obs(), {3'd2, 3'b000});
    detectSel = 1'b1; step(6);

    // R10 supply drop from listen
    goListen();
    supplyOk = 1'b0; step(3);
    check(10, obs(), {3'd0, 3'b001});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule